// File: doc/BRIEF.md
# Closed-Form Velocity Solver

This block turns six smoothed structure-tensor components per pixel into a two-component motion vector, in pixels per frame. Two cross-product numerators and one shared determinant are formed from the tensor terms. The quotient is then taken by multiplying by a reciprocal read from a small table, not by running a long divider.

The magnitude of the determinant is normalised by a leading-one search. Its top bits below the leading one index a table of 17-bit reciprocals, and the normalising shift is undone on the product. The pipeline accepts a pixel on every clock and returns it a fixed number of cycles later.

A determinant below a threshold marks the pixel as having no usable flow. In that case both outputs are forced to zero and a flag is raised.

Top module: `flow_solver`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles, and a new pixel can be accepted on every cycle.
- R2: When `flow_bad` is 0, `vx` approximates (t6·t4 − t5·t2)/(t1·t2 − t4²)·2^FRAC as a signed two's-complement value with FRAC = 8 fractional bits, within 2 LSB plus 1/128 of the exact magnitude.
- R3: When `flow_bad` is 0, `vy` approximates (t5·t4 − t6·t1)/(t1·t2 − t4²)·2^FRAC, within the same tolerance as R2.
- R4: A determinant t1·t2 − t4² below DET_MIN (default 1, so zero and negative values) gives `flow_bad` = 1 with `vx` = `vy` = 0. Any other determinant gives `flow_bad` = 0.
- R5: A quotient whose magnitude exceeds 2^(OUT_W−1)−1 is clamped to ±(2^(OUT_W−1)−1). The most negative code −2^(OUT_W−1) is never produced.
- R6: The sign of each output follows the sign of its numerator, and a zero numerator gives a zero output.
- R7: After reset, `out_valid`, `vx`, `vy` and `flow_bad` are all 0.
- R8: Results leave in the order the pixels entered. Cycles with `in_valid` low produce no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Tensor components are present this cycle |
| t1 | input | IN_W | Tensor term, xx diagonal (signed) |
| t2 | input | IN_W | Tensor term, yy diagonal (signed) |
| t3 | input | IN_W | Tensor term, temporal diagonal (signed, unused by the solve) |
| t4 | input | IN_W | Tensor term, xy (signed) |
| t5 | input | IN_W | Tensor term, xt (signed) |
| t6 | input | IN_W | Tensor term, yt (signed) |
| out_valid | output | 1 | Velocity result is present this cycle |
| vx | output | OUT_W | Horizontal velocity, signed, FRAC fractional bits |
| vy | output | OUT_W | Vertical velocity, signed, FRAC fractional bits |
| flow_bad | output | 1 | Determinant under threshold, outputs forced to zero |

## Verification
The assertions assume that the tensor terms are bounded by ±2^(IN_W−1), so every product and difference fits the internal width without wrapping. They also assume that `in_valid` is low throughout reset, because the latency and determinant checks start counting only from the end of reset.

The stimulus keeps the diagonal terms within 0 to 2000 and the off-diagonal terms within ±1000, well inside that range. Deliberate zero, negative, threshold-edge and tiny determinants are mixed with random bursts and gaps.

// File: rtl/flow_solver.sv
module flow_solver #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 16,
  parameter int FRAC    = 8,
  parameter int IDX_W   = 8,
  parameter int RW      = 17,
  parameter int DET_MIN = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  t1,
  input  logic signed [IN_W-1:0]  t2,
  input  logic signed [IN_W-1:0]  t3,
  input  logic signed [IN_W-1:0]  t4,
  input  logic signed [IN_W-1:0]  t5,
  input  logic signed [IN_W-1:0]  t6,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] vx,
  output logic signed [OUT_W-1:0] vy,
  output logic                    flow_bad
);
  localparam int DW    = 2*IN_W + 1;
  localparam int TAB_N = 1 << IDX_W;
  localparam int PW    = DW + RW;
  localparam int PBW   = $clog2(DW);
  localparam int SW    = $clog2(PW);
  localparam logic [OUT_W-1:0] MAXV = OUT_W'((1 << (OUT_W-1)) - 1);

  logic [RW-1:0] rtab [TAB_N];
  for (genvar gi = 0; gi < TAB_N; gi++) begin : g_rtab
    assign rtab[gi] = RW'((((64'd1 << RW) - 64'd1) * 64'(TAB_N)) / 64'(TAB_N + gi));
  end

  logic signed [DW-1:0] e1, e2, e4, e5, e6;
  assign e1 = DW'(t1);
  assign e2 = DW'(t2);
  assign e4 = DW'(t4);
  assign e5 = DW'(t5);
  assign e6 = DW'(t6);

  logic                 s1_v;
  logic signed [DW-1:0] s1_det, s1_nx, s1_ny;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_det <= '0;
      s1_nx  <= '0;
      s1_ny  <= '0;
    end else begin
      s1_v   <= in_valid;
      s1_det <= e1*e2 - e4*e4;
      s1_nx  <= e6*e4 - e5*e2;
      s1_ny  <= e5*e4 - e6*e1;
    end

  logic           bad_c;
  logic [DW-1:0]  mag, norm;
  logic [PBW-1:0] lead;
  logic [IDX_W-1:0] idx;

  assign bad_c = s1_det < DW'(DET_MIN);
  assign mag   = s1_det;

  always_comb begin
    lead = '0;
    for (int k = 0; k < DW; k++)
      if (mag[k]) lead = PBW'(k);
  end

  assign norm = mag << (PBW'(DW-1) - lead);
  assign idx  = norm[DW-2 -: IDX_W];

  logic           s2_v, s2_bad, s2_sx, s2_sy;
  logic [DW-1:0]  s2_ax, s2_ay;
  logic [RW-1:0]  s2_r;
  logic [SW-1:0]  s2_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_bad <= 1'b0;
      s2_sx  <= 1'b0;
      s2_sy  <= 1'b0;
      s2_ax  <= '0;
      s2_ay  <= '0;
      s2_r   <= '0;
      s2_sh  <= '0;
    end else begin
      s2_v   <= s1_v;
      s2_bad <= bad_c;
      s2_sx  <= s1_nx[DW-1];
      s2_sy  <= s1_ny[DW-1];
      s2_ax  <= s1_nx[DW-1] ? -s1_nx : s1_nx;
      s2_ay  <= s1_ny[DW-1] ? -s1_ny : s1_ny;
      s2_r   <= rtab[idx];
      s2_sh  <= SW'(RW - FRAC) + SW'(lead);
    end

  logic [PW-1:0]    qx, qy;
  logic [OUT_W-1:0] mx, my;

  assign qx = (PW'(s2_ax) * PW'(s2_r)) >> s2_sh;
  assign qy = (PW'(s2_ay) * PW'(s2_r)) >> s2_sh;
  assign mx = (qx > PW'(MAXV)) ? MAXV : qx[OUT_W-1:0];
  assign my = (qy > PW'(MAXV)) ? MAXV : qy[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      flow_bad  <= 1'b0;
      vx        <= '0;
      vy        <= '0;
    end else begin
      out_valid <= s2_v;
      flow_bad  <= s2_bad;
      vx        <= s2_bad ? '0 : (s2_sx ? -mx : mx);
      vy        <= s2_bad ? '0 : (s2_sy ? -my : my);
    end
endmodule

// File: rtl/flow_solver_chk.sv
module flow_solver_chk #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 16,
  parameter int FRAC    = 8,
  parameter int IDX_W   = 8,
  parameter int RW      = 17,
  parameter int DET_MIN = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  t1,
  input logic signed [IN_W-1:0]  t2,
  input logic signed [IN_W-1:0]  t3,
  input logic signed [IN_W-1:0]  t4,
  input logic signed [IN_W-1:0]  t5,
  input logic signed [IN_W-1:0]  t6,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] vx,
  input logic signed [OUT_W-1:0] vy,
  input logic                    flow_bad
);
  localparam int DW = 2*IN_W + 1;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  logic warm;
  assign warm = since_rst == 2'd3;

  logic signed [DW-1:0] det_now, nx_now, ny_now;
  assign det_now = DW'(t1)*DW'(t2) - DW'(t4)*DW'(t4);
  assign nx_now  = DW'(t6)*DW'(t4) - DW'(t5)*DW'(t2);
  assign ny_now  = DW'(t5)*DW'(t4) - DW'(t6)*DW'(t1);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  a_r4_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (flow_bad == ($past(det_now, 3) < DW'(DET_MIN))));

  a_r4_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flow_bad) |-> (vx == '0 && vy == '0));

  a_r5_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (vx != {1'b1, {(OUT_W-1){1'b0}}} && vy != {1'b1, {(OUT_W-1){1'b0}}}));

  a_r6_sign_x: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !flow_bad && vx != '0) |-> (vx[OUT_W-1] == $past(nx_now[DW-1], 3)));

  a_r6_sign_y: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !flow_bad && vy != '0) |-> (vy[OUT_W-1] == $past(ny_now[DW-1], 3)));
endmodule

bind flow_solver flow_solver_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .FRAC(FRAC), .IDX_W(IDX_W), .RW(RW), .DET_MIN(DET_MIN)
) chk_i (.*);

// File: tb/flow_solver_tb_top.sv
module flow_solver_tb_top;
  localparam int IN_W  = 16;
  localparam int OUT_W = 16;
  localparam int FRAC  = 8;
  localparam real MAXR = 32767.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] t1 = '0, t2 = '0, t3 = '0, t4 = '0, t5 = '0, t6 = '0;
  logic out_valid, flow_bad;
  logic signed [OUT_W-1:0] vx, vy;

  always #10 clk = ~clk;

  flow_solver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .t1(t1), .t2(t2), .t3(t3), .t4(t4), .t5(t5), .t6(t6),
    .out_valid(out_valid), .vx(vx), .vy(vy), .flow_bad(flow_bad)
  );

  typedef struct {
    real    ex;
    real    ey;
    bit     bad;
    longint stamp;
  } item_t;

  item_t  exp_q[$];
  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real clampr(real v);
    if (v > MAXR) return MAXR;
    if (v < -MAXR) return -MAXR;
    return v;
  endfunction

  function automatic real absr(real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic send(int a1, int a2, int a4, int a5, int a6);
    longint det, nx, ny;
    item_t it;
    @(negedge clk);
    t1 = IN_W'(a1); t2 = IN_W'(a2); t3 = IN_W'(a1 + a2);
    t4 = IN_W'(a4); t5 = IN_W'(a5); t6 = IN_W'(a6);
    in_valid = 1'b1;
    det = longint'(a1)*a2 - longint'(a4)*a4;
    nx  = longint'(a6)*a4 - longint'(a5)*a2;
    ny  = longint'(a5)*a4 - longint'(a6)*a1;
    it.bad   = det < 1;
    it.ex    = it.bad ? 0.0 : clampr(real'(nx) * 256.0 / real'(det));
    it.ey    = it.bad ? 0.0 : clampr(real'(ny) * 256.0 / real'(det));
    it.stamp = cyc + 3;
    exp_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic chk_val(string req, real got, real want);
    checks++;
    if (absr(got - want) > 2.0 + absr(want) / 128.0) begin
      errors++;
      $display("FAIL %s actual %0.1f expected %0.1f", req, got, want);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8 actual out_valid=1 expected no result pending");
        end else begin
          it = exp_q.pop_front();
          if (cyc != it.stamp) begin
            errors++;
            $display("FAIL R1 actual cycle %0d expected %0d", cyc, it.stamp);
          end
          checks++;
          if (flow_bad != it.bad) begin
            errors++;
            $display("FAIL R4 actual flag %0b expected %0b", flow_bad, it.bad);
          end
          if (it.bad) begin
            checks++;
            if (vx != 0 || vy != 0) begin
              errors++;
              $display("FAIL R4 actual vx=%0d vy=%0d expected 0 0", vx, vy);
            end
          end else begin
            chk_val("R2", real'(vx), it.ex);
            chk_val("R3", real'(vy), it.ey);
            if (absr(it.ex) >= MAXR) chk_val("R5", real'(vx), it.ex);
            if (it.ex == 0.0) begin
              checks++;
              if (vx != 0) begin
                errors++;
                $display("FAIL R6 actual %0d expected 0", vx);
              end
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || vx !== '0 || vy !== '0 || flow_bad !== 1'b0) begin
      errors++;
      $display("FAIL R7 actual ov=%0b vx=%0d vy=%0d bad=%0b expected all 0",
               out_valid, vx, vy, flow_bad);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R2 R3: vx = 2.0 (512), vy = -3.0 (-768)
    send(100, 100, 0, -200, 300);
    idle(4);
    // R6: zero numerators
    send(50, 80, 0, 0, 0);
    // R2 R3 with cross term
    send(400, 300, 100, 250, -120);
    idle(3);
    // R4: zero, negative, and threshold-edge determinants
    send(0, 500, 0, 10, 10);
    send(10, 10, 20, 5, 5);
    send(1, 1, 0, -1, 2);
    idle(2);
    // R5: saturation both signs
    send(1, 1, 0, -1000, 1000);
    send(1, 1, 0, 1000, -1000);
    idle(5);
    // R1 R8: back-to-back random burst with gaps
    for (int i = 0; i < 60; i++) begin
      send($urandom_range(2000), $urandom_range(2000),
           int'($urandom_range(2000)) - 1000,
           int'($urandom_range(2000)) - 1000,
           int'($urandom_range(2000)) - 1000);
      if (i % 7 == 3) idle(2);
    end
    idle(1);
    for (int i = 0; i < 40; i++) begin
      send($urandom_range(40000) % 2001, $urandom_range(2000),
           int'($urandom_range(60)) - 30,
           int'($urandom_range(2000)) - 1000,
           int'($urandom_range(2000)) - 1000);
    end
    idle(8);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 actual %0d results missing expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule